// File: doc/BRIEF.md
# Guest-Mode Control and Virtualization Trap Unit

This unit holds the one-bit execution-mode flag of a processor status word. Value 0 means the monitor is running and value 1 means a guest is running. All four privilege levels remain usable in either mode. In each cycle the unit looks at the decoded instruction class, the current privilege level and the effective virtual address. From these it decides whether execution has to leave the guest and enter the monitor.

In guest mode, privileged instructions and a chosen set of sensitive unprivileged instructions are not executed. Instead they raise a virtualization fault, and the cause code and the opcode are latched into two holding registers that the monitor can read. The topmost implemented virtual-address bit is kept for the monitor: a guest access that sets it faults. The mode flag is cleared whenever an interruption is delivered. A return-from-interruption or a direct mode-switch instruction can set the flag. The monitor can also register a pending virtual interrupt. When a guest later unmasks interrupts while one is pending, the unit requests the virtual external interrupt vector.

The reset input is asserted asynchronously and released through a two-stage synchroniser. Fault, address-fault and vector-request outputs are registered and appear one clock after the instruction or access that caused them.

Top module: `vt_guest_trap`

## Requirements
- R1: While reset is held and after it is released, mode is 0; vfault, addr_fault and virq_req are 0; fault_cause and fault_opcode are 0.
- R2: In guest mode (mode=1), a valid instruction of class 1 (privileged) or class 3 (return-from-interruption) causes vfault to pulse for one cycle in the next cycle. fault_cause becomes 2 and fault_opcode becomes that instruction's opcode.
- R3: In guest mode, a valid instruction of class 2 (sensitive unprivileged) causes a vfault pulse in the next cycle with fault_cause 3.
- R4: In monitor mode (mode=0), no input pattern raises vfault or addr_fault. A valid class 3 or class 4 instruction loads mode from new_mode at the next edge.
- R5: When intr_take is high at a clock edge, mode is 0 after that edge. This overrides any mode write, fault or vector request in the same cycle.
- R6: A valid class 4 instruction (mode switch) in guest mode at priv 0 loads mode from new_mode with no fault. At any priv other than 0 it faults with fault_cause 4.
- R7: In guest mode, va_valid with bit VA_W-1 of va set pulses both vfault and addr_fault in the next cycle with fault_cause 1. With that bit clear there is no fault.
- R8: Fault priority, highest first: address (cause 1), then privileged or return (cause 2), then guest mode-switch (cause 4), then sensitive (cause 3). A cycle produces at most one fault pulse.
- R9: A cycle that raises any fault leaves mode unchanged, unless intr_take is high in that cycle.
- R10: fault_cause and fault_opcode keep their values until the next fault.
- R11: virq_set and virq_clr change the pending flag only in monitor mode; when both are high, set wins. In guest mode, a valid class 5 instruction (interrupt unmask) while the flag is set and no fault is raised pulses virq_req in the next cycle and clears mode. Otherwise class 5 has no effect. Classes 0, 6 and 7 never fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | A decoded instruction is present this cycle |
| instr_class | input | 3 | Instruction class: 0 none, 1 privileged, 2 sensitive, 3 return, 4 mode switch, 5 unmask |
| instr_opcode | input | OPC_W (41) | Opcode of the decoded instruction |
| new_mode | input | 1 | Mode value carried by return and mode-switch instructions |
| priv | input | 2 | Current privilege level, 0 most privileged |
| intr_take | input | 1 | An interruption is being delivered this cycle |
| va_valid | input | 1 | Effective virtual address is valid |
| va | input | VA_W (48) | Effective virtual address |
| virq_set | input | 1 | Monitor registers a pending virtual interrupt |
| virq_clr | input | 1 | Monitor withdraws the pending virtual interrupt |
| mode | output | 1 | Current mode flag, 1 means guest |
| vfault | output | 1 | Virtualization fault pulse |
| fault_cause | output | 4 | Cause code of the last fault |
| fault_opcode | output | OPC_W (41) | Opcode captured at the last fault |
| addr_fault | output | 1 | Reserved-address fault pulse |
| virq_req | output | 1 | Virtual external interrupt vector request pulse |

## Verification
Each instruction class is applied in both modes, so that a trap that fires in the wrong mode or fails to fire in guest mode can be told apart. Addresses with the reserved bit set and clear, and addresses combined with trapping instructions, separate the address check from the instruction checks and expose any error in priority. Interruptions that coincide with mode writes and faults check precedence on the mode flag. A long stretch of random instruction, address and interrupt traffic is then compared against the reference model on every cycle.

// File: rtl/vt_pkg.sv
package vt_pkg;

  typedef enum logic [2:0] {
    IC_NONE   = 3'd0,
    IC_PRIV   = 3'd1,
    IC_SENS   = 3'd2,
    IC_RETURN = 3'd3,
    IC_SWITCH = 3'd4,
    IC_UNMASK = 3'd5
  } instr_class_e;

  localparam int CAUSE_W = 4;

  typedef enum logic [CAUSE_W-1:0] {
    FC_NONE   = 4'd0,
    FC_ADDR   = 4'd1,
    FC_PRIV   = 4'd2,
    FC_SENS   = 4'd3,
    FC_SWITCH = 4'd4
  } fault_cause_e;

  localparam logic MODE_MONITOR = 1'b0;
  localparam logic MODE_GUEST   = 1'b1;

endpackage

// File: rtl/vt_rst_sync.sv
module vt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/vt_mode_ctl.sv
module vt_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic intr_take,
  input  logic fault_any,
  input  logic virq_take,
  input  logic wr_en,
  input  logic wr_val,
  output logic mode
);
  import vt_pkg::*;

  logic mode_q;
  logic mode_d;
  logic mode_en;

  // Precedence: interruption, then fault hold, then vector transfer, then write.
  always_comb begin
    mode_en = 1'b0;
    mode_d  = mode_q;
    if (intr_take) begin
      mode_en = 1'b1;
      mode_d  = MODE_MONITOR;
    end else if (fault_any) begin
      mode_en = 1'b0;
      mode_d  = mode_q;
    end else if (virq_take) begin
      mode_en = 1'b1;
      mode_d  = MODE_MONITOR;
    end else if (wr_en) begin
      mode_en = 1'b1;
      mode_d  = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_MONITOR;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode = mode_q;

  p_intr_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    intr_take |=> (mode == MODE_MONITOR));

  p_fault_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any && !intr_take) |=> $stable(mode));

  p_vector_exits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    virq_take |=> (mode == MODE_MONITOR));

endmodule

// File: rtl/vt_fault_detect.sv
module vt_fault_detect #(
  parameter int VA_W  = 48,
  parameter int OPC_W = 41
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode,
  input  logic               instr_valid,
  input  logic [2:0]         instr_class,
  input  logic [OPC_W-1:0]   instr_opcode,
  input  logic [1:0]         priv,
  input  logic               va_valid,
  input  logic [VA_W-1:0]    va,
  output logic               fault_any,
  output logic               vfault,
  output logic               addr_fault,
  output logic [vt_pkg::CAUSE_W-1:0] fault_cause,
  output logic [OPC_W-1:0]   fault_opcode
);
  import vt_pkg::*;

  localparam int RSV_BIT = VA_W - 1;

  logic guest;
  logic hit_addr;
  logic hit_priv;
  logic hit_switch;
  logic hit_sens;
  fault_cause_e cause_sel;

  logic               vfault_q,  vfault_d;
  logic               afault_q,  afault_d;
  logic [CAUSE_W-1:0] cause_q,   cause_d;
  logic [OPC_W-1:0]   opc_q,     opc_d;
  logic               bank_en;

  assign guest = (mode == MODE_GUEST);

  // Candidate traps, each qualified by guest mode.
  always_comb begin
    hit_addr   = guest && va_valid && va[RSV_BIT];
    hit_priv   = 1'b0;
    hit_switch = 1'b0;
    hit_sens   = 1'b0;
    if (guest && instr_valid) begin
      case (instr_class)
        IC_PRIV, IC_RETURN: hit_priv   = 1'b1;
        IC_SENS:            hit_sens   = 1'b1;
        IC_SWITCH:          hit_switch = (priv != 2'd0);
        default: ;
      endcase
    end
  end

  // Fixed-priority select of a single cause.
  always_comb begin
    if (hit_addr)        cause_sel = FC_ADDR;
    else if (hit_priv)   cause_sel = FC_PRIV;
    else if (hit_switch) cause_sel = FC_SWITCH;
    else if (hit_sens)   cause_sel = FC_SENS;
    else                 cause_sel = FC_NONE;
  end

  assign fault_any = (cause_sel != FC_NONE);

  always_comb begin
    vfault_d = fault_any;
    afault_d = (cause_sel == FC_ADDR);
    bank_en  = fault_any;
    cause_d  = cause_sel;
    opc_d    = instr_opcode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vfault_q <= 1'b0;
      afault_q <= 1'b0;
    end else begin
      vfault_q <= vfault_d;
      afault_q <= afault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      opc_q   <= '0;
    end else if (bank_en) begin
      cause_q <= cause_d;
      opc_q   <= opc_d;
    end
  end

  assign vfault       = vfault_q;
  assign addr_fault   = afault_q;
  assign fault_cause  = cause_q;
  assign fault_opcode = opc_q;

  p_monitor_no_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MONITOR) |=> !vfault);

  p_addr_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_fault |-> (vfault && fault_cause == FC_ADDR));

  p_bank_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vfault |-> (fault_cause == FC_NONE || $stable(fault_cause) || $past(vfault)) );

  p_addr_beats_instr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (guest && va_valid && va[RSV_BIT]) |=> (fault_cause == FC_ADDR));

  p_cause_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vfault |-> (fault_cause inside {FC_ADDR, FC_PRIV, FC_SENS, FC_SWITCH}));

endmodule

// File: rtl/vt_virq.sv
module vt_virq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic       instr_valid,
  input  logic [2:0] instr_class,
  input  logic       fault_any,
  input  logic       virq_set,
  input  logic       virq_clr,
  output logic       virq_take,
  output logic       virq_req
);
  import vt_pkg::*;

  logic pend_q, pend_d, pend_en;
  logic req_q, req_d;
  logic monitor;

  assign monitor = (mode == MODE_MONITOR);

  always_comb begin
    pend_en = monitor && (virq_set || virq_clr);
    pend_d  = virq_set;
  end

  always_comb begin
    virq_take = !monitor && instr_valid && (instr_class == IC_UNMASK)
                && pend_q && !fault_any;
    req_d     = virq_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign virq_req = req_q;

  p_guest_cannot_touch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !monitor |=> $stable(pend_q));

  p_req_is_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    virq_req |=> !virq_req);

  p_req_needs_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    virq_req |-> $past(pend_q));

endmodule

// File: rtl/vt_guest_trap.sv
module vt_guest_trap #(
  parameter int VA_W  = 48,
  parameter int OPC_W = 41
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [2:0]       instr_class,
  input  logic [OPC_W-1:0] instr_opcode,
  input  logic             new_mode,
  input  logic [1:0]       priv,
  input  logic             intr_take,
  input  logic             va_valid,
  input  logic [VA_W-1:0]  va,
  input  logic             virq_set,
  input  logic             virq_clr,
  output logic             mode,
  output logic             vfault,
  output logic [3:0]       fault_cause,
  output logic [OPC_W-1:0] fault_opcode,
  output logic             addr_fault,
  output logic             virq_req
);
  import vt_pkg::*;

  logic rst_ns;
  logic fault_any;
  logic virq_take;
  logic wr_en;

  vt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  vt_fault_detect #(.VA_W(VA_W), .OPC_W(OPC_W)) u_fault (
    .clk          (clk),
    .rst_n        (rst_ns),
    .mode         (mode),
    .instr_valid  (instr_valid),
    .instr_class  (instr_class),
    .instr_opcode (instr_opcode),
    .priv         (priv),
    .va_valid     (va_valid),
    .va           (va),
    .fault_any    (fault_any),
    .vfault       (vfault),
    .addr_fault   (addr_fault),
    .fault_cause  (fault_cause),
    .fault_opcode (fault_opcode)
  );

  vt_virq u_virq (
    .clk         (clk),
    .rst_n       (rst_ns),
    .mode        (mode),
    .instr_valid (instr_valid),
    .instr_class (instr_class),
    .fault_any   (fault_any),
    .virq_set    (virq_set),
    .virq_clr    (virq_clr),
    .virq_take   (virq_take),
    .virq_req    (virq_req)
  );

  assign wr_en = instr_valid &&
                 ((instr_class == IC_RETURN) || (instr_class == IC_SWITCH));

  vt_mode_ctl u_mode (
    .clk       (clk),
    .rst_n     (rst_ns),
    .intr_take (intr_take),
    .fault_any (fault_any),
    .virq_take (virq_take),
    .wr_en     (wr_en),
    .wr_val    (new_mode),
    .mode      (mode)
  );

  p_one_pulse_kind_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    !(vfault && virq_req));

  p_vector_leaves_guest_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    virq_req |-> (mode == MODE_MONITOR));

endmodule

// File: tb/vt_guest_trap_test.sv
`timescale 1ns/1ps
module vt_guest_trap_test;
  localparam int VA_W  = 48;
  localparam int OPC_W = 41;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             instr_valid;
  logic [2:0]       instr_class;
  logic [OPC_W-1:0] instr_opcode;
  logic             new_mode;
  logic [1:0]       priv;
  logic             intr_take;
  logic             va_valid;
  logic [VA_W-1:0]  va;
  logic             virq_set;
  logic             virq_clr;
  logic             mode;
  logic             vfault;
  logic [3:0]       fault_cause;
  logic [OPC_W-1:0] fault_opcode;
  logic             addr_fault;
  logic             virq_req;

  always #4 clk = ~clk;

  vt_guest_trap #(.VA_W(VA_W), .OPC_W(OPC_W)) uut (.*);

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference model state
  bit             m_mode, m_pend, m_vf, m_af, m_vr;
  bit [3:0]       m_cause;
  bit [OPC_W-1:0] m_opc;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "mode", mode, m_mode);
    chk(tag, "vfault", vfault, m_vf);
    chk(tag, "addr_fault", addr_fault, m_af);
    chk(tag, "virq_req", virq_req, m_vr);
    chk(tag, "fault_cause", fault_cause, m_cause);
    chk(tag, "fault_opcode", fault_opcode, m_opc);
  endtask

  task automatic model_edge();
    bit g, a, p, w, s, f, take;
    int c;
    g = m_mode;
    a = g && va_valid && va[VA_W-1];
    p = g && instr_valid && (instr_class == 3'd1 || instr_class == 3'd3);
    w = g && instr_valid && instr_class == 3'd4 && priv != 2'd0;
    s = g && instr_valid && instr_class == 3'd2;
    c = a ? 1 : p ? 2 : w ? 4 : s ? 3 : 0;
    f = (c != 0);
    take = !f && g && instr_valid && instr_class == 3'd5 && m_pend;
    m_vf = f;
    m_af = (c == 1);
    m_vr = take;
    if (f) begin
      m_cause = 4'(c);
      m_opc   = instr_opcode;
    end
    if (!g) begin
      if (virq_set)      m_pend = 1;
      else if (virq_clr) m_pend = 0;
    end
    if (intr_take)    m_mode = 0;
    else if (f)       m_mode = m_mode;
    else if (take)    m_mode = 0;
    else if (instr_valid && (instr_class == 3'd3 || instr_class == 3'd4))
                      m_mode = new_mode;
  endtask

  task automatic idle_inputs();
    instr_valid = 0; instr_class = 0; instr_opcode = '0; new_mode = 0;
    priv = 0; intr_take = 0; va_valid = 0; va = '0; virq_set = 0; virq_clr = 0;
  endtask

  // One clock: inputs already set; update model at edge, compare at falling edge.
  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all(tag);
    idle_inputs();
  endtask

  task automatic ins(input logic [2:0] cls, input logic [OPC_W-1:0] opc,
                     input logic nm, input logic [1:0] pl);
    instr_valid = 1; instr_class = cls; instr_opcode = opc; new_mode = nm; priv = pl;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    m_mode = 0; m_pend = 0; m_vf = 0; m_af = 0; m_vr = 0; m_cause = 0; m_opc = '0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare_all("R1");

    // Monitor mode: nothing traps (R4)
    ins(3'd1, 41'h111, 0, 0); cyc("R4");
    ins(3'd2, 41'h222, 0, 3); cyc("R4");
    va_valid = 1; va = 48'h8000_0000_0001; cyc("R4");
    ins(3'd4, 41'h4, 0, 2); cyc("R4");
    ins(3'd3, 41'h333, 1, 0); cyc("R4");          // enter guest

    // Guest traps
    ins(3'd1, 41'h1AB, 0, 0); cyc("R2");
    cyc("R2");                                    // pulse ends
    ins(3'd3, 41'h3CD, 0, 0); cyc("R9");          // return traps, mode stays 1
    ins(3'd2, 41'h2EF, 0, 1); cyc("R3");
    va_valid = 1; va = 48'h7FFF_FFFF_FFFF; cyc("R7");
    va_valid = 1; va = 48'h8000_0000_0000; cyc("R7");
    ins(3'd1, 41'h155, 0, 0); va_valid = 1; va = 48'hFFFF_0000_0000; cyc("R8");
    ins(3'd2, 41'h166, 0, 0); ins(3'd4, 41'h177, 0, 1); cyc("R8");
    cyc("R10"); cyc("R10");
    ins(3'd4, 41'h188, 0, 2); cyc("R6");          // guest switch at priv 2 traps
    ins(3'd6, 41'h199, 0, 0); cyc("R11");         // unused class
    virq_set = 1; cyc("R11");                     // ignored in guest
    ins(3'd5, 41'h5, 0, 0); cyc("R11");           // nothing pending
    ins(3'd4, 41'h1, 1, 0); intr_take = 1; cyc("R5");
    ins(3'd1, 41'h2, 0, 0); cyc("R4");
    virq_set = 1; virq_clr = 1; cyc("R11");       // set wins
    ins(3'd5, 41'h5, 0, 0); cyc("R11");           // monitor unmask: no request
    ins(3'd4, 41'h6, 1, 0); cyc("R4");            // switch into guest
    ins(3'd5, 41'h7, 0, 3); cyc("R11");           // vector request
    cyc("R11");
    ins(3'd3, 41'h8, 1, 0); cyc("R4");
    ins(3'd5, 41'h9, 0, 0); va_valid = 1; va = 48'h8000_0000_0000; cyc("R8");
    ins(3'd4, 41'hA, 0, 0); cyc("R6");            // guest switch at priv 0 leaves
    virq_clr = 1; cyc("R11");
    ins(3'd4, 41'hB, 1, 0); cyc("R6");
    ins(3'd2, 41'hC, 0, 0); intr_take = 1; cyc("R5");

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      instr_valid  = $urandom_range(0, 3) != 0;
      instr_class  = 3'($urandom_range(0, 7));
      instr_opcode = {9'($urandom), 32'($urandom)};
      new_mode     = $urandom_range(0, 1) == 1;
      priv         = 2'($urandom_range(0, 3));
      intr_take    = $urandom_range(0, 15) == 0;
      va_valid     = $urandom_range(0, 1) == 1;
      va           = {16'($urandom), 32'($urandom)};
      virq_set     = $urandom_range(0, 7) == 0;
      virq_clr     = $urandom_range(0, 7) == 0;
      cyc("R8");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule